// File: doc/BRIEF.md
# Guarded Default-Settings Access Controller

This block decides who may change a set of power-up default settings. The defaults sit in a register set that models nonvolatile storage: it survives a warm reset and only returns to its factory value on a power-on reset. Next to it is a working copy, which the rest of the chip reads and which anyone may overwrite. Every warm reset reloads the working copy from the stored defaults.

Requests arrive as decoded one-cycle strobes:

- A working-copy write.
- A default write. It carries a new access mode and a new 8-byte password.
- A password presentation.

A single password field serves both the default write and the presentation.

Three access modes gate the default write:

- Open (code 0x00) accepts every default write.
- Guarded (code 0x40) accepts a default write only after the correct password has been presented since the last reset.
- Locked (code 0x80) is one-way. It refuses every default write for good, so the mode and the password are frozen too.

Each request gets one registered response with a command code and a status byte.

Top module: `cfg_guard`

## Requirements
- R1: On power-on reset (`por_n` low) the mode becomes 0x00, the stored defaults and the working copy both become `FACTORY_SET`, the stored password becomes all zero, `unlocked_o` is 0 and `rsp_valid_o` is 0.
- R2: A warm reset (`rst_n` low, `por_n` high) loads the working copy from the stored defaults. It clears the unlock. It keeps the stored defaults, the mode and the password unchanged.
- R3: A working-copy write is accepted in every mode. One cycle after the strobe, `work_o` holds the new data and the response is code 0x41 with status 0x00. The stored defaults are unchanged.
- R4: In mode 0x00 a default write is accepted. One cycle later it answers code 0x60 with status 0x00. In that same cycle `dflt_o` holds the new data and `mode_o` holds the new mode.
- R5: In mode 0x40 without an unlock, a default write answers code 0x60 with status 0xFB. Defaults, mode and password stay unchanged.
- R6: A password presentation answers with code 0x70. A match gives status 0x00 and sets the unlock. A mismatch gives status 0xFB and clears any earlier unlock.
- R7: In an accepted default write, an all-zero password field keeps the stored password. Any other value replaces it.
- R8: Once mode 0x80 is stored, every default write answers status 0xFB, even after a matching password. Mode, password and defaults never change again, and a warm reset does not leave mode 0x80.
- R9: A default write that is otherwise permitted but carries a mode code other than 0x00, 0x40 or 0x80 answers status 0xF8 and changes nothing.
- R10: Every cycle with at least one request strobe is followed by exactly one response cycle (`rsp_valid_o` high). A cycle with no strobe is followed by `rsp_valid_o` low. When strobes coincide, the password presentation wins over the default write, which wins over the working write; the losing strobes have no effect.
- R11: An unlock in mode 0x40 stays valid for any number of default writes until a warm reset or a mismatching password.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; restores factory state |
| rst_n | input | 1 | Warm reset, active low, synchronous; reloads the working copy |
| wr_work_i | input | 1 | Strobe: write working copy |
| wr_dflt_i | input | 1 | Strobe: write stored defaults |
| pass_i | input | 1 | Strobe: present password |
| data_i | input | SET_W | Settings value for either write |
| mode_i | input | 8 | New access mode code carried by a default write |
| pwd_i | input | 8*PWD_BYTES | New password (default write) or candidate (presentation) |
| rsp_valid_o | output | 1 | Response valid, one cycle after a request |
| rsp_code_o | output | 8 | Echoed command code: 0x41 working, 0x60 default, 0x70 password |
| rsp_status_o | output | 8 | 0x00 accepted, 0xFB blocked or mismatch, 0xF8 bad mode code |
| mode_o | output | 8 | Stored access mode code |
| unlocked_o | output | 1 | Correct password presented since last reset |
| dflt_o | output | SET_W | Stored default settings |
| work_o | output | SET_W | Working settings copy |

## Verification
The bound checker enforces the following on every cycle:

- The one-request-one-response rhythm.
- That a locked mode stays locked with frozen defaults.
- Rejection of default writes in locked mode and in guarded mode without an unlock.
- The working-copy reload and unlock clearing at a warm reset.

The bench scenarios cover what no per-cycle rule can see:

- That the password held across many commands is the one last written. This covers the all-zero field that keeps it and the replacement that makes the old password fail.
- That an unlock survives several writes but not a mismatch.
- That the losing strobes in a collision really leave the settings untouched.
- That the factory state returns only on power-on.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

   localparam logic [7:0] MODE_OPEN  = 8'h00;
   localparam logic [7:0] MODE_GUARD = 8'h40;
   localparam logic [7:0] MODE_LOCK  = 8'h80;

   localparam logic [7:0] OP_WORK = 8'h41;
   localparam logic [7:0] OP_DFLT = 8'h60;
   localparam logic [7:0] OP_PASS = 8'h70;

   localparam logic [7:0] ST_OK     = 8'h00;
   localparam logic [7:0] ST_BLOCK  = 8'hFB;
   localparam logic [7:0] ST_BADARG = 8'hF8;

   typedef enum logic [1:0] {
      ACC_OPEN  = 2'd0,
      ACC_GUARD = 2'd1,
      ACC_LOCK  = 2'd2
   } acc_e;

   typedef struct packed {
      logic work;
      logic dflt;
      logic pass;
   } req_t;

   function automatic logic mode_known(input logic [7:0] code);
      return (code == MODE_OPEN) || (code == MODE_GUARD) || (code == MODE_LOCK);
   endfunction

   function automatic acc_e mode_decode(input logic [7:0] code);
      acc_e r;
      case (code)
         MODE_GUARD: r = ACC_GUARD;
         MODE_LOCK:  r = ACC_LOCK;
         default:    r = ACC_OPEN;
      endcase
      return r;
   endfunction

   function automatic logic [7:0] mode_encode(input acc_e a);
      logic [7:0] r;
      case (a)
         ACC_GUARD: r = MODE_GUARD;
         ACC_LOCK:  r = MODE_LOCK;
         default:   r = MODE_OPEN;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/cfg_guard_cmp.sv
module cfg_guard_cmp #(
   parameter int PWD_BYTES = 8,
   localparam int PW = PWD_BYTES * 8
) (
   input  logic [PW-1:0] stored_i,
   input  logic [PW-1:0] cand_i,
   output logic          match_o,
   output logic          cand_zero_o
);

   logic [PWD_BYTES-1:0] byte_eq;
   logic [PWD_BYTES-1:0] byte_nz;

   for (genvar g = 0; g < PWD_BYTES; g++) begin : g_byte
      assign byte_eq[g] = (stored_i[g*8 +: 8] == cand_i[g*8 +: 8]);
      assign byte_nz[g] = |cand_i[g*8 +: 8];
   end

   assign match_o     = &byte_eq;
   assign cand_zero_o = ~|byte_nz;

endmodule

// File: rtl/cfg_guard_policy.sv
module cfg_guard_policy
   import cfg_guard_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       rst_n,
   input  req_t       req_i,
   input  logic       match_i,
   input  logic [7:0] mode_i,
   output logic [7:0] mode_o,
   output logic       unlocked_o,
   output logic       dflt_we_o,
   output logic       work_we_o,
   output logic [7:0] code_o,
   output logic [7:0] status_o
);

   acc_e acc_q;
   logic unl_q;
   logic allowed;

   always_comb begin
      case (acc_q)
         ACC_OPEN:  allowed = 1'b1;
         ACC_GUARD: allowed = unl_q;
         default:   allowed = 1'b0;
      endcase
   end

   always_comb begin
      dflt_we_o = 1'b0;
      work_we_o = 1'b0;
      code_o    = OP_WORK;
      status_o  = ST_OK;
      if (req_i.pass) begin
         code_o   = OP_PASS;
         status_o = match_i ? ST_OK : ST_BLOCK;
      end else if (req_i.dflt) begin
         code_o = OP_DFLT;
         if (!allowed) begin
            status_o = ST_BLOCK;
         end else if (!mode_known(mode_i)) begin
            status_o = ST_BADARG;
         end else begin
            dflt_we_o = 1'b1;
         end
      end else if (req_i.work) begin
         work_we_o = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!por_n) begin
         acc_q <= ACC_OPEN;
         unl_q <= 1'b0;
      end else if (!rst_n) begin
         unl_q <= 1'b0;
      end else begin
         if (req_i.pass) unl_q <= match_i;
         if (dflt_we_o)  acc_q <= mode_decode(mode_i);
      end
   end

   assign mode_o     = mode_encode(acc_q);
   assign unlocked_o = unl_q;

endmodule

// File: rtl/cfg_guard_store.sv
module cfg_guard_store #(
   parameter int SET_W = 32,
   parameter int PWD_BYTES = 8,
   parameter logic [SET_W-1:0] FACTORY_SET = '0,
   localparam int PW = PWD_BYTES * 8
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             rst_n,
   input  logic             work_we_i,
   input  logic             dflt_we_i,
   input  logic             keep_pwd_i,
   input  logic [SET_W-1:0] data_i,
   input  logic [PW-1:0]    pwd_i,
   output logic [SET_W-1:0] dflt_o,
   output logic [SET_W-1:0] work_o,
   output logic [PW-1:0]    pwd_o
);

   logic [SET_W-1:0] dflt_q;
   logic [SET_W-1:0] work_q;
   logic [PW-1:0]    pwd_q;

   always_ff @(posedge clk) begin
      if (!por_n) begin
         dflt_q <= FACTORY_SET;
         work_q <= FACTORY_SET;
         pwd_q  <= '0;
      end else if (!rst_n) begin
         work_q <= dflt_q;
      end else begin
         if (work_we_i) work_q <= data_i;
         if (dflt_we_i) begin
            dflt_q <= data_i;
            if (!keep_pwd_i) pwd_q <= pwd_i;
         end
      end
   end

   assign dflt_o = dflt_q;
   assign work_o = work_q;
   assign pwd_o  = pwd_q;

endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
   import cfg_guard_pkg::*;
#(
   parameter int SET_W = 32,
   parameter int PWD_BYTES = 8,
   parameter logic [SET_W-1:0] FACTORY_SET = 32'hA5A5_0F0F,
   localparam int PW = PWD_BYTES * 8
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             rst_n,
   input  logic             wr_work_i,
   input  logic             wr_dflt_i,
   input  logic             pass_i,
   input  logic [SET_W-1:0] data_i,
   input  logic [7:0]       mode_i,
   input  logic [PW-1:0]    pwd_i,
   output logic             rsp_valid_o,
   output logic [7:0]       rsp_code_o,
   output logic [7:0]       rsp_status_o,
   output logic [7:0]       mode_o,
   output logic             unlocked_o,
   output logic [SET_W-1:0] dflt_o,
   output logic [SET_W-1:0] work_o
);

   if (SET_W < 1) begin : g_bad_set_w
      $error("cfg_guard: SET_W must be at least 1");
   end
   if (PWD_BYTES < 1) begin : g_bad_pwd
      $error("cfg_guard: PWD_BYTES must be at least 1");
   end

   logic       live;
   req_t       req;
   logic       match, cand_zero;
   logic       dflt_we, work_we;
   logic [7:0] code_n, status_n;
   logic [PW-1:0] pwd_stored;

   assign live     = por_n & rst_n;
   assign req.work = live & wr_work_i;
   assign req.dflt = live & wr_dflt_i;
   assign req.pass = live & pass_i;

   cfg_guard_cmp #(.PWD_BYTES(PWD_BYTES)) u_cmp (
      .stored_i    (pwd_stored),
      .cand_i      (pwd_i),
      .match_o     (match),
      .cand_zero_o (cand_zero)
   );

   cfg_guard_policy u_policy (
      .clk        (clk),
      .por_n      (por_n),
      .rst_n      (rst_n),
      .req_i      (req),
      .match_i    (match),
      .mode_i     (mode_i),
      .mode_o     (mode_o),
      .unlocked_o (unlocked_o),
      .dflt_we_o  (dflt_we),
      .work_we_o  (work_we),
      .code_o     (code_n),
      .status_o   (status_n)
   );

   cfg_guard_store #(
      .SET_W       (SET_W),
      .PWD_BYTES   (PWD_BYTES),
      .FACTORY_SET (FACTORY_SET)
   ) u_store (
      .clk        (clk),
      .por_n      (por_n),
      .rst_n      (rst_n),
      .work_we_i  (work_we),
      .dflt_we_i  (dflt_we),
      .keep_pwd_i (cand_zero),
      .data_i     (data_i),
      .pwd_i      (pwd_i),
      .dflt_o     (dflt_o),
      .work_o     (work_o),
      .pwd_o      (pwd_stored)
   );

   always_ff @(posedge clk) begin
      if (!live) begin
         rsp_valid_o  <= 1'b0;
         rsp_code_o   <= 8'h00;
         rsp_status_o <= 8'h00;
      end else begin
         rsp_valid_o <= req.work | req.dflt | req.pass;
         if (req.work | req.dflt | req.pass) begin
            rsp_code_o   <= code_n;
            rsp_status_o <= status_n;
         end
      end
   end

endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk
   import cfg_guard_pkg::*;
#(
   parameter int SET_W = 32
) (
   input logic             clk,
   input logic             por_n,
   input logic             rst_n,
   input logic             wr_work_i,
   input logic             wr_dflt_i,
   input logic             pass_i,
   input logic             rsp_valid_o,
   input logic [7:0]       rsp_code_o,
   input logic [7:0]       rsp_status_o,
   input logic [7:0]       mode_o,
   input logic             unlocked_o,
   input logic [SET_W-1:0] dflt_o,
   input logic [SET_W-1:0] work_o
);

   logic any_req;
   assign any_req = wr_work_i | wr_dflt_i | pass_i;

   p_one_rsp_r10: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      any_req |=> rsp_valid_o);

   p_no_rsp_idle_r10: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      !any_req |=> !rsp_valid_o);

   p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
      (mode_o == MODE_LOCK) |=> (mode_o == MODE_LOCK) && $stable(dflt_o));

   p_lock_reject_r8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (wr_dflt_i && !pass_i && mode_o == MODE_LOCK) |=> (rsp_status_o == ST_BLOCK));

   p_guard_reject_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (wr_dflt_i && !pass_i && mode_o == MODE_GUARD && !unlocked_o)
      |=> (rsp_status_o == ST_BLOCK) && $stable(dflt_o) && $stable(mode_o));

   p_work_any_mode_r3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (wr_work_i && !wr_dflt_i && !pass_i)
      |=> (rsp_code_o == OP_WORK) && (rsp_status_o == ST_OK));

   p_reload_r2: assert property (@(posedge clk) disable iff (!por_n)
      !rst_n |=> (work_o == $past(dflt_o)) && !unlocked_o);

endmodule

bind cfg_guard cfg_guard_chk #(.SET_W(SET_W)) u_chk (
   .clk          (clk),
   .por_n        (por_n),
   .rst_n        (rst_n),
   .wr_work_i    (wr_work_i),
   .wr_dflt_i    (wr_dflt_i),
   .pass_i       (pass_i),
   .rsp_valid_o  (rsp_valid_o),
   .rsp_code_o   (rsp_code_o),
   .rsp_status_o (rsp_status_o),
   .mode_o       (mode_o),
   .unlocked_o   (unlocked_o),
   .dflt_o       (dflt_o),
   .work_o       (work_o)
);

// File: tb/cfg_guard_tb.sv
`timescale 1ns/1ps
module cfg_guard_tb;

   localparam int SET_W = 32;
   localparam int PWD_BYTES = 8;
   localparam int PW = PWD_BYTES * 8;
   localparam logic [SET_W-1:0] FACT = 32'hA5A5_0F0F;
   localparam logic [PW-1:0] PW_A = 64'h0102_0304_0506_0708;
   localparam logic [PW-1:0] PW_B = 64'hDEAD_BEEF_0BAD_F00D;
   localparam logic [PW-1:0] PW_X = 64'h0102_0304_0506_0709;

   logic clk = 1'b0;
   logic por_n = 1'b0, rst_n = 1'b0;
   logic wr_work_i = 1'b0, wr_dflt_i = 1'b0, pass_i = 1'b0;
   logic [SET_W-1:0] data_i = '0;
   logic [7:0] mode_i = 8'h00;
   logic [PW-1:0] pwd_i = '0;
   logic rsp_valid_o, unlocked_o;
   logic [7:0] rsp_code_o, rsp_status_o, mode_o;
   logic [SET_W-1:0] dflt_o, work_o;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   cfg_guard #(.SET_W(SET_W), .PWD_BYTES(PWD_BYTES), .FACTORY_SET(FACT)) u_dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n),
      .wr_work_i(wr_work_i), .wr_dflt_i(wr_dflt_i), .pass_i(pass_i),
      .data_i(data_i), .mode_i(mode_i), .pwd_i(pwd_i),
      .rsp_valid_o(rsp_valid_o), .rsp_code_o(rsp_code_o), .rsp_status_o(rsp_status_o),
      .mode_o(mode_o), .unlocked_o(unlocked_o), .dflt_o(dflt_o), .work_o(work_o)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drives one request cycle; returns at the next falling edge with the response visible.
   task automatic issue(input logic w, input logic d, input logic p,
                        input logic [SET_W-1:0] dat, input logic [7:0] md, input logic [PW-1:0] pw);
      @(negedge clk);
      wr_work_i = w; wr_dflt_i = d; pass_i = p;
      data_i = dat; mode_i = md; pwd_i = pw;
      @(negedge clk);
      wr_work_i = 1'b0; wr_dflt_i = 1'b0; pass_i = 1'b0;
   endtask

   task automatic rsp(input string req, input logic [7:0] code, input logic [7:0] st);
      check({req, " valid"}, 64'(rsp_valid_o), 64'd1);
      check({req, " code"}, 64'(rsp_code_o), 64'(code));
      check({req, " status"}, 64'(rsp_status_o), 64'(st));
   endtask

   task automatic warm_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_power_on();
      @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;
      check("R1 mode", 64'(mode_o), 64'h00);
      check("R1 dflt", 64'(dflt_o), 64'(FACT));
      check("R1 work", 64'(work_o), 64'(FACT));
      check("R1 unlocked", 64'(unlocked_o), 64'd0);
      check("R1 rsp_valid", 64'(rsp_valid_o), 64'd0);
      issue(1'b0, 1'b0, 1'b1, '0, 8'h00, '0);
      rsp("R1 zero pwd", 8'h70, 8'h00);
   endtask

   task automatic t_open_mode();
      issue(1'b1, 1'b0, 1'b0, 32'h1111_1111, 8'h00, '0);
      rsp("R3 open", 8'h41, 8'h00);
      check("R3 work", 64'(work_o), 64'h1111_1111);
      check("R3 dflt untouched", 64'(dflt_o), 64'(FACT));
      @(negedge clk);
      check("R10 idle", 64'(rsp_valid_o), 64'd0);
      issue(1'b0, 1'b1, 1'b0, 32'h2222_2222, 8'h00, '0);
      rsp("R4 open", 8'h60, 8'h00);
      check("R4 dflt", 64'(dflt_o), 64'h2222_2222);
      check("R4 work kept", 64'(work_o), 64'h1111_1111);
      warm_reset();
      check("R2 reload", 64'(work_o), 64'h2222_2222);
      check("R2 dflt kept", 64'(dflt_o), 64'h2222_2222);
   endtask

   task automatic t_bad_mode();
      issue(1'b0, 1'b1, 1'b0, 32'h9999_9999, 8'h33, PW_A);
      rsp("R9 bad mode", 8'h60, 8'hF8);
      check("R9 dflt", 64'(dflt_o), 64'h2222_2222);
      check("R9 mode", 64'(mode_o), 64'h00);
      issue(1'b0, 1'b0, 1'b1, '0, 8'h00, PW_A);
      rsp("R9 pwd unchanged", 8'h70, 8'hFB);
   endtask

   task automatic t_guard();
      issue(1'b0, 1'b1, 1'b0, 32'h3333_3333, 8'h40, PW_A);
      rsp("R4 set guard", 8'h60, 8'h00);
      check("R4 mode", 64'(mode_o), 64'h40);
      issue(1'b0, 1'b1, 1'b0, 32'h4444_4444, 8'h40, '0);
      rsp("R5 reject", 8'h60, 8'hFB);
      check("R5 dflt", 64'(dflt_o), 64'h3333_3333);
      issue(1'b1, 1'b0, 1'b0, 32'h4545_4545, 8'h00, '0);
      rsp("R3 guard", 8'h41, 8'h00);
      check("R3 guard work", 64'(work_o), 64'h4545_4545);
      issue(1'b0, 1'b0, 1'b1, '0, 8'h00, PW_X);
      rsp("R6 wrong", 8'h70, 8'hFB);
      check("R6 wrong unlocked", 64'(unlocked_o), 64'd0);
      issue(1'b0, 1'b0, 1'b1, '0, 8'h00, PW_A);
      rsp("R6 right", 8'h70, 8'h00);
      check("R6 unlocked", 64'(unlocked_o), 64'd1);
      issue(1'b0, 1'b1, 1'b0, 32'h5555_5555, 8'h40, '0);
      rsp("R11 first", 8'h60, 8'h00);
      issue(1'b0, 1'b1, 1'b0, 32'h6666_6666, 8'h40, '0);
      rsp("R11 second", 8'h60, 8'h00);
      check("R11 dflt", 64'(dflt_o), 64'h6666_6666);
      issue(1'b0, 1'b0, 1'b1, '0, 8'h00, PW_X);
      check("R6 relock", 64'(unlocked_o), 64'd0);
      issue(1'b0, 1'b1, 1'b0, 32'h7070_7070, 8'h40, '0);
      rsp("R6 after wrong", 8'h60, 8'hFB);
      issue(1'b0, 1'b0, 1'b1, '0, 8'h00, PW_A);
      rsp("R7 zero kept", 8'h70, 8'h00);
      issue(1'b0, 1'b1, 1'b0, 32'h7777_7777, 8'h40, PW_B);
      rsp("R7 replace", 8'h60, 8'h00);
      issue(1'b0, 1'b0, 1'b1, '0, 8'h00, PW_A);
      rsp("R7 old fails", 8'h70, 8'hFB);
      issue(1'b0, 1'b0, 1'b1, '0, 8'h00, PW_B);
      rsp("R7 new ok", 8'h70, 8'h00);
      warm_reset();
      check("R2 unlock cleared", 64'(unlocked_o), 64'd0);
      check("R2 mode kept", 64'(mode_o), 64'h40);
      check("R2 work", 64'(work_o), 64'h7777_7777);
   endtask

   task automatic t_priority();
      issue(1'b1, 1'b1, 1'b1, 32'hABAB_ABAB, 8'h00, PW_B);
      rsp("R10 pass wins", 8'h70, 8'h00);
      check("R10 dflt dropped", 64'(dflt_o), 64'h7777_7777);
      check("R10 work dropped", 64'(work_o), 64'h7777_7777);
      check("R10 mode", 64'(mode_o), 64'h40);
      @(negedge clk);
      check("R10 single rsp", 64'(rsp_valid_o), 64'd0);
      issue(1'b1, 1'b1, 1'b0, 32'hCDCD_CDCD, 8'h40, '0);
      rsp("R10 dflt wins", 8'h60, 8'h00);
      check("R10 work dropped 2", 64'(work_o), 64'h7777_7777);
   endtask

   task automatic t_lock();
      issue(1'b0, 1'b1, 1'b0, 32'h8888_8888, 8'h80, '0);
      rsp("R8 set lock", 8'h60, 8'h00);
      check("R8 mode", 64'(mode_o), 64'h80);
      issue(1'b0, 1'b1, 1'b0, 32'h1234_5678, 8'h00, '0);
      rsp("R8 reject", 8'h60, 8'hFB);
      issue(1'b0, 1'b0, 1'b1, '0, 8'h00, PW_B);
      rsp("R8 pwd kept", 8'h70, 8'h00);
      issue(1'b0, 1'b1, 1'b0, 32'h1234_5678, 8'h00, PW_A);
      rsp("R8 reject unlocked", 8'h60, 8'hFB);
      check("R8 dflt frozen", 64'(dflt_o), 64'h8888_8888);
      check("R8 mode frozen", 64'(mode_o), 64'h80);
      issue(1'b1, 1'b0, 1'b0, 32'hF0F0_F0F0, 8'h00, '0);
      rsp("R3 lock", 8'h41, 8'h00);
      warm_reset();
      check("R8 after reset", 64'(mode_o), 64'h80);
      check("R2 lock reload", 64'(work_o), 64'h8888_8888);
      t_power_on();
   endtask

   initial begin
      #800000;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_power_on();
      t_open_mode();
      t_bad_mode();
      t_guard();
      t_priority();
      t_lock();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule